// File: doc/BRIEF.md
# Bridge Configuration Register File with Side-Effect Strobes

This block holds the bridge-specific part of a Type 1 configuration header for a PCI-to-PCI bridge. Configuration writes arrive as a byte address, a 32-bit data word and four byte enables, and reads return the addressed dword through a combinational read port. Besides storing values, the block reports two events to the surrounding bridge logic. A remap strobe tells the forwarding decoder that a window register may have changed. A secondary-reset strobe tells the secondary bus to perform a hot reset when software newly sets the bus-reset bit in the bridge control word.

The address windows are the I/O, memory and prefetchable memory base/limit pairs, plus their upper extensions. Their low nibbles are fixed type codes, and only the address bits above them are stored. A one-cycle "forwarding off" command programs every window so that its base lies above its limit, which closes all windows at once. The identity fields are constants. Both status words advertise 66 MHz and fast back-to-back capability, the class code names a PCI-to-PCI bridge, and the header type selects the bridge layout while keeping the multi-function bit given by a parameter.

Top module: `p2p_cfg_regs`

## Requirements
- R1: While reset is asserted, and after it is released, the bus-number dword (0x18), the bridge control word (bytes 0x3E-0x3F), the stored address bits of every window and all upper window registers read zero. The window type nibbles stay at their fixed values, so with the defaults 0x1C reads 0x00A00101 and 0x24 reads 0x00010001.
- R2: A write changes only the bytes whose byte enable is set. Byte enable bit k selects data bits 8k+7:8k and byte address (dword base + k).
- R3: The low four bits of each window base and limit register ignore writes. They read 0x1 for I/O (IO_32BIT=1), 0x0 for memory and 0x1 for prefetchable (PREF_64BIT=1).
- R4: A write with at least one enabled byte at address 0x1C or 0x1D raises remap_pulse for exactly one cycle, starting on the cycle after the write.
- R5: A write with at least one enabled byte anywhere in 0x20-0x33 raises remap_pulse for exactly one cycle, starting on the cycle after the write.
- R6: A write that enables no byte in 0x1C-0x1D or 0x20-0x33 leaves remap_pulse low. This covers writes to the status bytes 0x1E-0x1F, to 0x34 and above, and writes with all byte enables clear.
- R7: When a write changes bridge-control bit 6 (dword 0x3C bit 22, byte enable 2) from 0 to 1, sec_rst_pulse is high for exactly one cycle, starting on the cycle after the write.
- R8: sec_rst_pulse stays low when bit 6 is rewritten while already 1, when it is cleared, and when a write changes only other control bits.
- R9: A cycle with fwd_off high sets every stored window base address bit and clears every stored limit address bit. It also zeroes the four upper registers. For those registers it takes priority over a write in the same cycle, and it leaves bus numbers and bridge control unchanged.
- R10: Reads return the constant identity fields: 0x00 = {DEVICE_ID, VENDOR_ID}, 0x04 = 0x00A00000, 0x08 = {0x060400, REVISION}, 0x0C = 0x00810000 with MULTI_FUNC=1, and the secondary status at 0x1E-0x1F = 0x00A0.
- R11: Addresses with no register behind them read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe, one write per cycle |
| cfg_waddr | input | ADDR_W | Write byte address (bits 1:0 ignored) |
| cfg_wdata | input | 32 | Write data |
| cfg_wbe | input | 4 | Write byte enables |
| cfg_raddr | input | ADDR_W | Read byte address (bits 1:0 ignored) |
| cfg_rdata | output | 32 | Read data, combinational from cfg_raddr |
| fwd_off | input | 1 | Close all forwarding windows |
| remap_pulse | output | 1 | One-cycle strobe after a write touching a window |
| sec_rst_pulse | output | 1 | One-cycle secondary hot-reset strobe |

## Verification
The hardest situation to reach is the secondary-reset edge detection. It needs the control bit to be already set before a rewrite, then cleared, and then set again through the single byte lane that carries it while the other lane is written on its own. A stimulus table therefore walks bridge control through 0x0040, 0x0041, 0x0001, 0xFF01 and 0xFF40 in order. A second hard case is the overlap boundary of the remap spans. The table writes the status half of dword 0x1C with its lower half disabled, and it writes the dwords just inside (0x30) and just outside (0x34) the upper span. Directed steps then collide fwd_off with a window write and re-arm the reset edge after a mid-run reset.

// File: rtl/p2p_cfg_pkg.sv
package p2p_cfg_pkg;

   // byte offsets whose position is decoded by neighbouring logic
   localparam logic [5:0] OFS_BUS  = 6'h18;
   localparam logic [5:0] OFS_IO   = 6'h1C;
   localparam logic [5:0] OFS_MEM  = 6'h20;
   localparam logic [5:0] OFS_PREF = 6'h24;
   localparam logic [5:0] OFS_PBU  = 6'h28;
   localparam logic [5:0] OFS_PLU  = 6'h2C;
   localparam logic [5:0] OFS_IOU  = 6'h30;
   localparam logic [5:0] OFS_CTL  = 6'h3E;

   // spans whose overlap with a write triggers a remap
   localparam int SPAN_A_LO = 'h1C;
   localparam int SPAN_A_HI = 'h1D;
   localparam int SPAN_B_LO = 'h20;
   localparam int SPAN_B_HI = 'h33;

   localparam int          CTL_BUSRST_BIT = 6;
   localparam logic [15:0] STATUS_CAPS    = 16'h00A0;
   localparam logic [23:0] CLASS_P2P      = 24'h060400;
   localparam logic [6:0]  HDR_BRIDGE     = 7'h01;

   // expand four byte enables into a 32-bit bit mask
   function automatic logic [31:0] lanes32(input logic [3:0] be);
      logic [31:0] m;
      for (int k = 0; k < 4; k++) m[8*k +: 8] = {8{be[k]}};
      return m;
   endfunction

endpackage

// File: rtl/p2p_cfg_wdec.sv
module p2p_cfg_wdec
   import p2p_cfg_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [3:0]        be,
   output logic [63:0]       byte_we,
   output logic              remap_hit
);
   logic       in_space;
   logic [3:0] dw;

   assign dw = addr[5:2];

   if (ADDR_W > 6) begin : g_hi
      assign in_space = (addr[ADDR_W-1:6] == '0);
   end else begin : g_lo
      assign in_space = 1'b1;
   end

   for (genvar i = 0; i < 64; i++) begin : g_byte
      assign byte_we[i] = wr && in_space && (dw == 4'(i / 4)) && be[i % 4];
   end

   assign remap_hit = (|byte_we[SPAN_A_HI:SPAN_A_LO]) | (|byte_we[SPAN_B_HI:SPAN_B_LO]);
endmodule

// File: rtl/p2p_cfg_window.sv
module p2p_cfg_window
   import p2p_cfg_pkg::*;
#(
   parameter int         W    = 16,
   parameter logic [3:0] TYPE = 4'h0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [W/8-1:0]  base_we,
   input  logic [W/8-1:0]  lim_we,
   input  logic [W-1:0]    base_wd,
   input  logic [W-1:0]    lim_wd,
   input  logic            fwd_off,
   output logic [W-1:0]    base_rd,
   output logic [W-1:0]    lim_rd
);
   localparam int         NB   = W / 8;
   localparam logic [W-1:0] MASK = {{(W-4){1'b1}}, 4'h0};

   if (W != 8 && W != 16) begin : g_bad_w
      $error("p2p_cfg_window: W must be 8 or 16");
   end

   logic [W-1:0] base_q, lim_q, bmask, lmask;
   logic [31:0]  bl32, ll32;

   assign bl32  = lanes32(4'(base_we));
   assign ll32  = lanes32(4'(lim_we));
   assign bmask = bl32[W-1:0] & MASK;
   assign lmask = ll32[W-1:0] & MASK;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         lim_q  <= '0;
      end else if (fwd_off) begin
         base_q <= MASK;
         lim_q  <= '0;
      end else begin
         base_q <= (base_q & ~bmask) | (base_wd & bmask);
         lim_q  <= (lim_q & ~lmask) | (lim_wd & lmask);
      end
   end

   assign base_rd = base_q | W'(TYPE);
   assign lim_rd  = lim_q | W'(TYPE);

   logic unused_nb;
   assign unused_nb = (NB == 0);
endmodule

// File: rtl/p2p_cfg_upper.sv
module p2p_cfg_upper
   import p2p_cfg_pkg::*;
#(
   parameter int W      = 32,
   parameter bit ENABLE = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [W/8-1:0]  base_we,
   input  logic [W/8-1:0]  lim_we,
   input  logic [W-1:0]    base_wd,
   input  logic [W-1:0]    lim_wd,
   input  logic            fwd_off,
   output logic [W-1:0]    base_rd,
   output logic [W-1:0]    lim_rd
);
   if (W != 16 && W != 32) begin : g_bad_w
      $error("p2p_cfg_upper: W must be 16 or 32");
   end

   if (ENABLE) begin : g_on
      logic [W-1:0] base_q, lim_q, bmask, lmask;
      logic [31:0]  bl32, ll32;

      assign bl32  = lanes32(4'(base_we));
      assign ll32  = lanes32(4'(lim_we));
      assign bmask = bl32[W-1:0];
      assign lmask = ll32[W-1:0];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            base_q <= '0;
            lim_q  <= '0;
         end else if (fwd_off) begin
            base_q <= '0;
            lim_q  <= '0;
         end else begin
            base_q <= (base_q & ~bmask) | (base_wd & bmask);
            lim_q  <= (lim_q & ~lmask) | (lim_wd & lmask);
         end
      end

      assign base_rd = base_q;
      assign lim_rd  = lim_q;
   end else begin : g_off
      logic unused_in;
      assign unused_in = ^{clk, rst_n, base_we, lim_we, base_wd, lim_wd, fwd_off};
      assign base_rd = '0;
      assign lim_rd  = '0;
   end
endmodule

// File: rtl/p2p_cfg_ctl.sv
module p2p_cfg_ctl
   import p2p_cfg_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic [3:0]  bus_we,
   input  logic [1:0]  ctl_we,
   input  logic [31:0] wdata,
   output logic [31:0] bus_rd,
   output logic [15:0] ctl_rd,
   output logic        sec_rst_pulse
);
   logic [31:0] bus_q, bus_mask, ctl32;
   logic [15:0] ctl_q, ctl_next;
   logic        sec_q;

   assign bus_mask = lanes32(bus_we);
   assign ctl32    = lanes32({2'b00, ctl_we});
   assign ctl_next = (ctl_q & ~ctl32[15:0]) | (wdata[31:16] & ctl32[15:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_q <= '0;
         ctl_q <= '0;
         sec_q <= 1'b0;
      end else begin
         bus_q <= (bus_q & ~bus_mask) | (wdata & bus_mask);
         ctl_q <= ctl_next;
         sec_q <= ~ctl_q[CTL_BUSRST_BIT] & ctl_next[CTL_BUSRST_BIT];
      end
   end

   assign bus_rd        = bus_q;
   assign ctl_rd        = ctl_q;
   assign sec_rst_pulse = sec_q;

   logic unused_ctl;
   assign unused_ctl = ^ctl32[31:16];
endmodule

// File: rtl/p2p_cfg_regs.sv
module p2p_cfg_regs
   import p2p_cfg_pkg::*;
#(
   parameter int          ADDR_W     = 8,
   parameter logic [15:0] VENDOR_ID  = 16'hABCD,
   parameter logic [15:0] DEVICE_ID  = 16'h1234,
   parameter logic [7:0]  REVISION   = 8'h02,
   parameter bit          MULTI_FUNC = 1'b1,
   parameter bit          IO_32BIT   = 1'b1,
   parameter bit          PREF_64BIT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [ADDR_W-1:0] cfg_waddr,
   input  logic [31:0]       cfg_wdata,
   input  logic [3:0]        cfg_wbe,
   input  logic [ADDR_W-1:0] cfg_raddr,
   output logic [31:0]       cfg_rdata,
   input  logic              fwd_off,
   output logic              remap_pulse,
   output logic              sec_rst_pulse
);
   localparam logic [3:0] IO_TYPE   = IO_32BIT   ? 4'h1 : 4'h0;
   localparam logic [3:0] PREF_TYPE = PREF_64BIT ? 4'h1 : 4'h0;

   if (ADDR_W < 6 || ADDR_W > 12) begin : g_bad_addr
      $error("p2p_cfg_regs: ADDR_W must lie in 6..12");
   end

   logic [63:0] bwe;
   logic        remap_hit, remap_q;
   logic [7:0]  io_base, io_lim;
   logic [15:0] mem_base, mem_lim, pref_base, pref_lim, iobu, iolu;
   logic [31:0] pbu_rd, plu_rd, bus_rd;
   logic [15:0] ctl_word;

   p2p_cfg_wdec #(.ADDR_W(ADDR_W)) u_wdec (
      .wr(cfg_wr), .addr(cfg_waddr), .be(cfg_wbe),
      .byte_we(bwe), .remap_hit(remap_hit)
   );

   p2p_cfg_window #(.W(8), .TYPE(IO_TYPE)) u_io (
      .clk, .rst_n,
      .base_we(bwe[OFS_IO]), .lim_we(bwe[OFS_IO + 6'd1]),
      .base_wd(cfg_wdata[7:0]), .lim_wd(cfg_wdata[15:8]),
      .fwd_off, .base_rd(io_base), .lim_rd(io_lim)
   );

   p2p_cfg_window #(.W(16), .TYPE(4'h0)) u_mem (
      .clk, .rst_n,
      .base_we(bwe[OFS_MEM +: 2]), .lim_we(bwe[OFS_MEM + 6'd2 +: 2]),
      .base_wd(cfg_wdata[15:0]), .lim_wd(cfg_wdata[31:16]),
      .fwd_off, .base_rd(mem_base), .lim_rd(mem_lim)
   );

   p2p_cfg_window #(.W(16), .TYPE(PREF_TYPE)) u_pref (
      .clk, .rst_n,
      .base_we(bwe[OFS_PREF +: 2]), .lim_we(bwe[OFS_PREF + 6'd2 +: 2]),
      .base_wd(cfg_wdata[15:0]), .lim_wd(cfg_wdata[31:16]),
      .fwd_off, .base_rd(pref_base), .lim_rd(pref_lim)
   );

   p2p_cfg_upper #(.W(32), .ENABLE(PREF_64BIT)) u_pref_up (
      .clk, .rst_n,
      .base_we(bwe[OFS_PBU +: 4]), .lim_we(bwe[OFS_PLU +: 4]),
      .base_wd(cfg_wdata), .lim_wd(cfg_wdata),
      .fwd_off, .base_rd(pbu_rd), .lim_rd(plu_rd)
   );

   p2p_cfg_upper #(.W(16), .ENABLE(IO_32BIT)) u_io_up (
      .clk, .rst_n,
      .base_we(bwe[OFS_IOU +: 2]), .lim_we(bwe[OFS_IOU + 6'd2 +: 2]),
      .base_wd(cfg_wdata[15:0]), .lim_wd(cfg_wdata[31:16]),
      .fwd_off, .base_rd(iobu), .lim_rd(iolu)
   );

   p2p_cfg_ctl u_ctl (
      .clk, .rst_n,
      .bus_we(bwe[OFS_BUS +: 4]), .ctl_we(bwe[OFS_CTL +: 2]),
      .wdata(cfg_wdata), .bus_rd(bus_rd), .ctl_rd(ctl_word),
      .sec_rst_pulse(sec_rst_pulse)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) remap_q <= 1'b0;
      else        remap_q <= remap_hit;
   end
   assign remap_pulse = remap_q;

   // read path
   logic       rd_in_space;
   logic [3:0] rd_dw;
   assign rd_dw = cfg_raddr[5:2];

   if (ADDR_W > 6) begin : g_rd_hi
      assign rd_in_space = (cfg_raddr[ADDR_W-1:6] == '0);
   end else begin : g_rd_lo
      assign rd_in_space = 1'b1;
   end

   always_comb begin
      cfg_rdata = '0;
      if (rd_in_space) begin
         case (rd_dw)
            4'd0:           cfg_rdata = {DEVICE_ID, VENDOR_ID};
            4'd1:           cfg_rdata = {STATUS_CAPS, 16'h0000};
            4'd2:           cfg_rdata = {CLASS_P2P, REVISION};
            4'd3:           cfg_rdata = {8'h00, MULTI_FUNC, HDR_BRIDGE, 16'h0000};
            OFS_BUS[5:2]:   cfg_rdata = bus_rd;
            OFS_IO[5:2]:    cfg_rdata = {STATUS_CAPS, io_lim, io_base};
            OFS_MEM[5:2]:   cfg_rdata = {mem_lim, mem_base};
            OFS_PREF[5:2]:  cfg_rdata = {pref_lim, pref_base};
            OFS_PBU[5:2]:   cfg_rdata = pbu_rd;
            OFS_PLU[5:2]:   cfg_rdata = plu_rd;
            OFS_IOU[5:2]:   cfg_rdata = {iolu, iobu};
            OFS_CTL[5:2]:   cfg_rdata = {ctl_word, 16'h0000};
            default:        cfg_rdata = '0;
         endcase
      end
   end

   logic unused_bits;
   assign unused_bits = ^{bwe, cfg_raddr[1:0]};
endmodule

// File: rtl/p2p_cfg_chk.sv
module p2p_cfg_chk #(
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_wr,
   input logic [ADDR_W-1:0] cfg_waddr,
   input logic [3:0]        cfg_wbe,
   input logic              fwd_off,
   input logic              remap_pulse,
   input logic              sec_rst_pulse,
   input logic [15:0]       ctl_q,
   input logic [31:0]       pbu,
   input logic [31:0]       plu,
   input logic [15:0]       iobu,
   input logic [15:0]       iolu
);
   AST_REMAP_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      remap_pulse |-> ($past(cfg_wr) && $past(cfg_wbe) != 4'h0)); // R4

   AST_REMAP_IN_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
      remap_pulse |-> ($past(cfg_waddr[ADDR_W-1:2]) == (ADDR_W-2)'(7) ||
                       ($past(cfg_waddr[ADDR_W-1:2]) >= (ADDR_W-2)'(8) &&
                        $past(cfg_waddr[ADDR_W-1:2]) <= (ADDR_W-2)'(12)))); // R5

   AST_SECRST_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      sec_rst_pulse |-> (ctl_q[6] && !$past(ctl_q[6]) && $past(cfg_wr))); // R7

   AST_SECRST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      sec_rst_pulse |=> !sec_rst_pulse); // R8

   AST_FWD_OFF_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $past(fwd_off) |-> (pbu == 32'h0 && plu == 32'h0 && iobu == 16'h0 && iolu == 16'h0)); // R9
endmodule

bind p2p_cfg_regs p2p_cfg_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_waddr(cfg_waddr),
   .cfg_wbe(cfg_wbe), .fwd_off(fwd_off), .remap_pulse(remap_pulse),
   .sec_rst_pulse(sec_rst_pulse), .ctl_q(ctl_word), .pbu(pbu_rd),
   .plu(plu_rd), .iobu(iobu), .iolu(iolu)
);

// File: tb/p2p_cfg_regs_test.sv
`timescale 1ns/1ps
module p2p_cfg_regs_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [7:0]  cfg_waddr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [3:0]  cfg_wbe = '0;
   logic [7:0]  cfg_raddr = '0;
   logic [31:0] cfg_rdata;
   logic        fwd_off = 1'b0;
   logic        remap_pulse, sec_rst_pulse;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   p2p_cfg_regs uut (
      .clk, .rst_n, .cfg_wr, .cfg_waddr, .cfg_wdata, .cfg_wbe,
      .cfg_raddr, .cfg_rdata, .fwd_off, .remap_pulse, .sec_rst_pulse
   );

   // {req, addr, be, data, exp_remap, exp_sec, exp_readback}
   localparam int NV = 16;
   localparam logic [81:0] VEC [NV] = '{
      {4'd6,  8'h18, 4'hF, 32'h40050100, 1'b0, 1'b0, 32'h40050100}, // R6 bus numbers
      {4'd3,  8'h1C, 4'h3, 32'hFFFFA5F3, 1'b1, 1'b0, 32'h00A0A1F1}, // R3 R4 I/O pair
      {4'd6,  8'h1C, 4'hC, 32'hFFFF0000, 1'b0, 1'b0, 32'h00A0A1F1}, // R6 status half only
      {4'd2,  8'h1C, 4'h2, 32'h00003000, 1'b1, 1'b0, 32'h00A031F1}, // R2 R4 limit byte
      {4'd5,  8'h20, 4'hF, 32'h1234567F, 1'b1, 1'b0, 32'h12305670}, // R5 R3 memory
      {4'd2,  8'h24, 4'h1, 32'h000000FF, 1'b1, 1'b0, 32'h000100F1}, // R2 prefetch low byte
      {4'd5,  8'h28, 4'hF, 32'hDEADBEEF, 1'b1, 1'b0, 32'hDEADBEEF}, // R5 upper base
      {4'd2,  8'h2C, 4'h5, 32'h11223344, 1'b1, 1'b0, 32'h00220044}, // R2 upper limit
      {4'd5,  8'h30, 4'hF, 32'hCAFEBABE, 1'b1, 1'b0, 32'hCAFEBABE}, // R5 end of span
      {4'd11, 8'h34, 4'hF, 32'hFFFFFFFF, 1'b0, 1'b0, 32'h00000000}, // R11 R6 past span
      {4'd7,  8'h3C, 4'hC, 32'h00400000, 1'b0, 1'b1, 32'h00400000}, // R7 first set
      {4'd8,  8'h3C, 4'hC, 32'h00410000, 1'b0, 1'b0, 32'h00410000}, // R8 already set
      {4'd8,  8'h3C, 4'hC, 32'h00010000, 1'b0, 1'b0, 32'h00010000}, // R8 cleared
      {4'd8,  8'h3C, 4'h8, 32'hFF000000, 1'b0, 1'b0, 32'hFF010000}, // R8 other lane
      {4'd7,  8'h3C, 4'h4, 32'h00400000, 1'b0, 1'b1, 32'hFF400000}, // R7 set via lane 2
      {4'd6,  8'h3C, 4'h0, 32'hFFFFFFFF, 1'b0, 1'b0, 32'hFF400000}  // R6 no enables
   };

   task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp,
                        input string what);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] v);
      cfg_raddr = a;
      #1;
      v = cfg_rdata;
   endtask

   task automatic wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d,
                     input logic off);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_waddr = a; cfg_wbe = be; cfg_wdata = d; fwd_off = off;
      @(negedge clk);
      cfg_wr = 1'b0; cfg_wbe = '0; fwd_off = 1'b0;
      #1;
   endtask

   task automatic check_reset_state(input string tag);
      logic [31:0] v;
      rd(8'h18, v); check(1, v, 32'h00000000, {tag, " bus numbers"});
      rd(8'h1C, v); check(1, v, 32'h00A00101, {tag, " io pair"});
      rd(8'h20, v); check(1, v, 32'h00000000, {tag, " mem pair"});
      rd(8'h24, v); check(1, v, 32'h00010001, {tag, " pref pair"});
      rd(8'h28, v); check(1, v, 32'h00000000, {tag, " pref upper base"});
      rd(8'h2C, v); check(1, v, 32'h00000000, {tag, " pref upper limit"});
      rd(8'h30, v); check(1, v, 32'h00000000, {tag, " io upper"});
      rd(8'h3C, v); check(1, v, 32'h00000000, {tag, " bridge control"});
      check(1, {31'h0, remap_pulse}, 32'h0, {tag, " remap"});
      check(1, {31'h0, sec_rst_pulse}, 32'h0, {tag, " sec reset"});
   endtask

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      check_reset_state("R1 in reset");
      rst_n = 1'b1;
      @(negedge clk); #1;
      check_reset_state("R1 after release");

      // R10 identity fields
      rd(8'h00, v); check(10, v, 32'h1234ABCD, "ids");
      rd(8'h04, v); check(10, v, 32'h00A00000, "primary status");
      rd(8'h08, v); check(10, v, 32'h06040002, "class and revision");
      rd(8'h0C, v); check(10, v, 32'h00810000, "header type");
      rd(8'h40, v); check(11, v, 32'h00000000, "beyond header");

      for (int i = 0; i < NV; i++) begin
         logic [81:0] e;
         int          req;
         e   = VEC[i];
         req = int'(e[81:78]);
         wr(e[77:70], e[69:66], e[65:34], 1'b0);
         check(req, {31'h0, remap_pulse}, {31'h0, e[33]}, $sformatf("vec %0d remap", i));
         check(req, {31'h0, sec_rst_pulse}, {31'h0, e[32]}, $sformatf("vec %0d sec reset", i));
         rd(e[77:70], v);
         check(req, v, e[31:0], $sformatf("vec %0d readback", i));
         @(negedge clk); #1;
         // R4 R7 strobes last a single cycle
         check(req, {30'h0, remap_pulse, sec_rst_pulse}, 32'h0, $sformatf("vec %0d strobe end", i));
      end

      // R9 forwarding off collides with a memory window write
      wr(8'h20, 4'hF, 32'h00000000, 1'b1);
      rd(8'h1C, v); check(9, v, 32'h00A001F1, "io closed");
      rd(8'h20, v); check(9, v, 32'h0000FFF0, "mem closed over write");
      rd(8'h24, v); check(9, v, 32'h0001FFF1, "pref closed");
      rd(8'h28, v); check(9, v, 32'h00000000, "pref upper base zero");
      rd(8'h2C, v); check(9, v, 32'h00000000, "pref upper limit zero");
      rd(8'h30, v); check(9, v, 32'h00000000, "io upper zero");
      rd(8'h18, v); check(9, v, 32'h40050100, "bus numbers kept");
      rd(8'h3C, v); check(9, v, 32'hFF400000, "control kept");

      // R1 reset in mid-run, then the edge detector re-arms (R7)
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); #1;
      check_reset_state("R1 mid-run reset");
      rst_n = 1'b1;
      wr(8'h3C, 4'h4, 32'h00400000, 1'b0);
      check(7, {31'h0, sec_rst_pulse}, 32'h1, "sec reset after re-reset");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule